// File: doc/BRIEF.md
# Asynchronous External Memory Bus Sequencer

This block runs the pins of a single chip-select region on an external parallel memory bus. It serves asynchronous SRAM, FRAM, PSRAM and NOR parts. A requester places one access at a time on a valid/acknowledge port. The access carries the address, the write data, the byte enables and the direction. The block then walks the bus through its phases. Byte-lane strobes fall first. Chip select follows after a set delay. Then come the address phase, an optional address-hold phase, the strobe phase and the data-hold phase. The acknowledge is a single pulse, and for a read it comes with the captured data.

Every phase length is a clock-cycle count on a configuration input. Reads and writes take their address setup, address hold, data setup, data hold and turnaround from two separate sets of inputs. The byte-lane lead time is one value shared by both directions. Address and data can share the data pins for PSRAM and NOR parts. A device wait input can stretch the strobe phase, and its active level can be chosen. The data path runs 16 bits wide or 8 bits narrow.

Top module: `xbus_async_seq`

## Requirements
- R1: For a read, the strobe phase holds `xb_oe_n` low and `xb_we_n` high for max(1, read data-setup) cycles. The data-hold phase that follows keeps chip select low with both strobes high for exactly the read data-hold count.
- R2: A write takes all of its phase lengths from the write set. It holds `xb_we_n` low for max(1, write data-setup) cycles. Through the strobe and data-hold phases it drives `xb_dq_out` = write data with `xb_dq_oe` = 1. A read never drives `xb_dq_oe` in those phases.
- R3: Multiplexing is active only when `cfg_mux` = 1 and `cfg_kind` is 1 (PSRAM) or 2 (NOR). Kind 0 (SRAM/FRAM) and kind 3 turn it off. When it is active, `xb_adv_n` is low for the address-setup count. An address-hold phase of the address-hold count follows. In both phases `xb_dq_oe` = 1 and `xb_dq_out` carries the address.
- R4: Before chip select falls, the byte-lane strobes are low for `cfg_lane` cycles with `xb_cs_n` high. Each lane strobe is low exactly for an enabled byte, and only from this lane-lead phase through data hold.
- R5: After the acknowledge cycle, the bus stays idle for exactly the turnaround count of the finished access's direction. Only then can the next access begin, when that access is presented in the acknowledge cycle.
- R6: A phase whose count is zero is skipped entirely, except the strobe phase, which always lasts at least one cycle.
- R7: With `cfg_wait_en` = 0, the wait input has no effect on any phase length.
- R8: With `cfg_wait_en` = 1, the wait input is asserted when it equals `cfg_wait_hi` (0 = active low, the default). Each cycle it is asserted during the strobe phase lengthens that phase by one cycle.
- R9: `ack` is high for exactly one cycle, the first cycle after the access's last active bus cycle. For a read, `rd_data` then holds the `xb_dq_in` value present in the last strobe cycle.
- R10: `cfg_bus8` = 1 selects 8-bit width, and 0 selects 16-bit. In 8-bit mode, lane 0 is strobed on every access and lane 1 stays high. Read data and driven data have their upper byte zero.
- R11: `xb_oe_n` and `xb_we_n` are never low together, and either one being low implies `xb_cs_n` is low. After reset all strobes and the chip select are high and `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_kind | input | 2 | Device kind: 0 SRAM/FRAM, 1 PSRAM, 2 NOR |
| cfg_mux | input | 1 | Request address/data sharing of the data pins |
| cfg_bus8 | input | 1 | 1 = 8-bit data path, 0 = 16-bit |
| cfg_wait_en | input | 1 | Honour the wait input during accesses |
| cfg_wait_hi | input | 1 | Wait input is active high when 1 |
| cfg_lane | input | TW | Byte-lane lead cycles before chip select |
| cfg_rd_aset | input | TW | Read address-setup cycles |
| cfg_rd_ahld | input | TW | Read address-hold cycles (multiplexed only) |
| cfg_rd_dset | input | TW | Read data-setup cycles |
| cfg_rd_dhld | input | TW | Read data-hold cycles |
| cfg_rd_turn | input | TW | Idle cycles after a read |
| cfg_wr_aset | input | TW | Write address-setup cycles |
| cfg_wr_ahld | input | TW | Write address-hold cycles (multiplexed only) |
| cfg_wr_dset | input | TW | Write data-setup cycles |
| cfg_wr_dhld | input | TW | Write data-hold cycles |
| cfg_wr_turn | input | TW | Idle cycles after a write |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| xb_cs_n | output | 1 | Chip select, active low |
| xb_oe_n | output | 1 | Output enable, active low |
| xb_we_n | output | 1 | Write enable, active low |
| xb_adv_n | output | 1 | Address-valid latch strobe, active low |
| xb_bl_n | output | DW/8 | Byte-lane strobes, active low |
| xb_addr | output | AW | Address pins |
| xb_dq_out | output | DW | Data pins, outgoing value |
| xb_dq_oe | output | 1 | Data pin drive enable |
| xb_dq_in | input | DW | Data pins, incoming value |
| xb_wait | input | 1 | Device wait input |

## Verification
The assertions take some behaviour of the requester for granted. It holds `req_valid` and the request fields steady until `ack`, and it presents the next request or drops `req_valid` in the acknowledge cycle. The configuration changes only in that cycle or while the bus is idle. The wait input is taken to be synchronous to `clk`. The bench follows these rules by changing request and configuration only at the falling edge where it sees `ack`. It drives `xb_wait` and `xb_dq_in` only at falling edges, so each value is settled well before the rising edge that samples it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LANE = 3'd1,
    PH_ASET = 3'd2,
    PH_AHLD = 3'd3,
    PH_DSET = 3'd4,
    PH_DHLD = 3'd5,
    PH_TURN = 3'd6
  } phase_t;

  localparam int NUM_PH = 7;

  localparam logic [1:0] KIND_SRAM  = 2'd0;
  localparam logic [1:0] KIND_PSRAM = 2'd1;
  localparam logic [1:0] KIND_NOR   = 2'd2;

endpackage

// File: rtl/xbus_timing_sel.sv
module xbus_timing_sel #(
  parameter int TW = 4
) (
  input  logic          dir_wr,
  input  logic          mux_on,
  input  logic [TW-1:0] lane,
  input  logic [TW-1:0] rd_aset,
  input  logic [TW-1:0] rd_ahld,
  input  logic [TW-1:0] rd_dset,
  input  logic [TW-1:0] rd_dhld,
  input  logic [TW-1:0] rd_turn,
  input  logic [TW-1:0] wr_aset,
  input  logic [TW-1:0] wr_ahld,
  input  logic [TW-1:0] wr_dset,
  input  logic [TW-1:0] wr_dhld,
  input  logic [TW-1:0] wr_turn,
  output logic [TW-1:0] len_lane,
  output logic [TW-1:0] len_aset,
  output logic [TW-1:0] len_ahld,
  output logic [TW-1:0] len_dset,
  output logic [TW-1:0] len_dhld,
  output logic [TW-1:0] len_turn
);

  logic [TW-1:0] raw_dset;

  always_comb begin
    len_lane = lane;
    len_aset = dir_wr ? wr_aset : rd_aset;
    len_ahld = mux_on ? (dir_wr ? wr_ahld : rd_ahld) : '0;
    raw_dset = dir_wr ? wr_dset : rd_dset;
    len_dset = (raw_dset == '0) ? TW'(1) : raw_dset;
    len_dhld = dir_wr ? wr_dhld : rd_dhld;
    len_turn = dir_wr ? wr_turn : rd_turn;
  end

endmodule

// File: rtl/xbus_phase_ctl.sv
module xbus_phase_ctl import xbus_pkg::*; #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wait_act,
  input  logic [TW-1:0] len_lane,
  input  logic [TW-1:0] len_aset,
  input  logic [TW-1:0] len_ahld,
  input  logic [TW-1:0] len_dset,
  input  logic [TW-1:0] len_dhld,
  input  logic [TW-1:0] len_turn,
  output phase_t        phase_q,
  output logic          ack_q,
  output logic          cap
);

  logic [TW-1:0] len_arr [NUM_PH];
  logic [TW-1:0] cnt_q;
  phase_t        nxt;
  logic          found;
  logic          hold;
  logic          advance;
  logic          ending;

  always_comb begin
    len_arr[0] = '0;
    len_arr[1] = len_lane;
    len_arr[2] = len_aset;
    len_arr[3] = len_ahld;
    len_arr[4] = len_dset;
    len_arr[5] = len_dhld;
    len_arr[6] = len_turn;
  end

  // first later phase with a non-zero length; none left means idle
  always_comb begin
    nxt   = PH_IDLE;
    found = 1'b0;
    for (int p = 1; p < NUM_PH; p++) begin
      if (!found && (p > int'(phase_q)) && (len_arr[p] != '0)) begin
        nxt   = phase_t'(3'(p));
        found = 1'b1;
      end
    end
  end

  assign hold    = (phase_q == PH_DSET) && wait_act;
  assign advance = (phase_q == PH_IDLE) ? start : ((cnt_q == '0) && !hold);
  assign ending  = advance && ((phase_q == PH_DSET) || (phase_q == PH_DHLD)) &&
                   ((nxt == PH_TURN) || (nxt == PH_IDLE));
  assign cap     = advance && (phase_q == PH_DSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= ending;
      if (advance) begin
        phase_q <= nxt;
        cnt_q   <= (nxt == PH_IDLE) ? '0 : (len_arr[nxt] - TW'(1));
      end else if ((phase_q != PH_IDLE) && !hold) begin
        cnt_q <= cnt_q - TW'(1);
      end
    end
  end

  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

  p_wait_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DSET && wait_act) |=> (phase_q == PH_DSET && $stable(cnt_q)));

  p_turn_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TURN && cnt_q == '0) |=> (phase_q == PH_IDLE));

  p_ack_after_data_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> ($past(phase_q) == PH_DSET || $past(phase_q) == PH_DHLD));

endmodule

// File: rtl/xbus_pin_drv.sv
module xbus_pin_drv import xbus_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  input  phase_t        phase,
  input  logic          mux_on,
  input  logic          bus8,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic          cs_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          adv_n,
  output logic [BW-1:0] bl_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rd_data,
  output logic          dir_q
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] width_mask;
  logic [DW-1:0] addr_lo;
  logic          in_lane, in_cs, in_addr, in_data;
  logic [BW-1:0] lane_en;

  assign width_mask = bus8 ? DW'(8'hFF) : '1;
  assign addr_lo    = DW'(addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        dir_q   <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (cap && !dir_q) begin
        rd_q <= dq_in & width_mask;
      end
    end
  end

  always_comb begin
    in_cs   = (phase == PH_ASET) || (phase == PH_AHLD) ||
              (phase == PH_DSET) || (phase == PH_DHLD);
    in_lane = in_cs || (phase == PH_LANE);
    in_addr = (phase == PH_ASET) || (phase == PH_AHLD);
    in_data = (phase == PH_DSET) || (phase == PH_DHLD);
  end

  genvar g;
  generate
    for (g = 0; g < BW; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign lane_en[g] = bus8 || be_q[g];
      end else begin : g_upper
        assign lane_en[g] = !bus8 && be_q[g];
      end
      assign bl_n[g] = !(in_lane && lane_en[g]);
    end
  endgenerate

  always_comb begin
    cs_n  = !in_cs;
    oe_n  = !((phase == PH_DSET) && !dir_q);
    we_n  = !((phase == PH_DSET) && dir_q);
    adv_n = !((phase == PH_ASET) && mux_on);
    dq_oe = (in_addr && mux_on) || (in_data && dir_q);
    if (in_addr && mux_on) begin
      dq_out = addr_lo & width_mask;
    end else if (in_data && dir_q) begin
      dq_out = wdata_q & width_mask;
    end else begin
      dq_out = '0;
    end
  end

  assign addr    = addr_q;
  assign rd_data = rd_q;

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  p_cs_covers_r11: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |-> !cs_n);

  p_adv_drives_r3: assert property (@(posedge clk) disable iff (rst)
    !adv_n |-> (dq_oe && !cs_n));

  p_read_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);

endmodule

// File: rtl/xbus_async_seq.sv
module xbus_async_seq import xbus_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 4,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_kind,
  input  logic          cfg_mux,
  input  logic          cfg_bus8,
  input  logic          cfg_wait_en,
  input  logic          cfg_wait_hi,
  input  logic [TW-1:0] cfg_lane,
  input  logic [TW-1:0] cfg_rd_aset,
  input  logic [TW-1:0] cfg_rd_ahld,
  input  logic [TW-1:0] cfg_rd_dset,
  input  logic [TW-1:0] cfg_rd_dhld,
  input  logic [TW-1:0] cfg_rd_turn,
  input  logic [TW-1:0] cfg_wr_aset,
  input  logic [TW-1:0] cfg_wr_ahld,
  input  logic [TW-1:0] cfg_wr_dset,
  input  logic [TW-1:0] cfg_wr_dhld,
  input  logic [TW-1:0] cfg_wr_turn,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic          xb_cs_n,
  output logic          xb_oe_n,
  output logic          xb_we_n,
  output logic          xb_adv_n,
  output logic [BW-1:0] xb_bl_n,
  output logic [AW-1:0] xb_addr,
  output logic [DW-1:0] xb_dq_out,
  output logic          xb_dq_oe,
  input  logic [DW-1:0] xb_dq_in,
  input  logic          xb_wait
);

  phase_t        phase;
  logic          dir_q, dir_eff, mux_on, wait_act, accept, cap;
  logic [TW-1:0] l_lane, l_aset, l_ahld, l_dset, l_dhld, l_turn;

  assign mux_on   = cfg_mux && ((cfg_kind == KIND_PSRAM) || (cfg_kind == KIND_NOR));
  assign wait_act = cfg_wait_en && (cfg_wait_hi ? xb_wait : !xb_wait);
  assign accept   = (phase == PH_IDLE) && req_valid;
  assign dir_eff  = (phase == PH_IDLE) ? req_write : dir_q;

  xbus_timing_sel #(.TW(TW)) u_tsel (
    .dir_wr  (dir_eff),
    .mux_on  (mux_on),
    .lane    (cfg_lane),
    .rd_aset (cfg_rd_aset),
    .rd_ahld (cfg_rd_ahld),
    .rd_dset (cfg_rd_dset),
    .rd_dhld (cfg_rd_dhld),
    .rd_turn (cfg_rd_turn),
    .wr_aset (cfg_wr_aset),
    .wr_ahld (cfg_wr_ahld),
    .wr_dset (cfg_wr_dset),
    .wr_dhld (cfg_wr_dhld),
    .wr_turn (cfg_wr_turn),
    .len_lane(l_lane),
    .len_aset(l_aset),
    .len_ahld(l_ahld),
    .len_dset(l_dset),
    .len_dhld(l_dhld),
    .len_turn(l_turn)
  );

  xbus_phase_ctl #(.TW(TW)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .wait_act(wait_act),
    .len_lane(l_lane),
    .len_aset(l_aset),
    .len_ahld(l_ahld),
    .len_dset(l_dset),
    .len_dhld(l_dhld),
    .len_turn(l_turn),
    .phase_q (phase),
    .ack_q   (ack),
    .cap     (cap)
  );

  xbus_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .phase    (phase),
    .mux_on   (mux_on),
    .bus8     (cfg_bus8),
    .cap      (cap),
    .dq_in    (xb_dq_in),
    .cs_n     (xb_cs_n),
    .oe_n     (xb_oe_n),
    .we_n     (xb_we_n),
    .adv_n    (xb_adv_n),
    .bl_n     (xb_bl_n),
    .addr     (xb_addr),
    .dq_out   (xb_dq_out),
    .dq_oe    (xb_dq_oe),
    .rd_data  (rd_data),
    .dir_q    (dir_q)
  );

  p_no_mux_sram_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_kind == KIND_SRAM) |-> xb_adv_n);

endmodule

// File: tb/tb_xbus_async_seq.sv
module tb_xbus_async_seq;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam logic [15:0] RBASE = 16'h3A50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_kind = '0;
  logic cfg_mux = 0, cfg_bus8 = 0, cfg_wait_en = 0, cfg_wait_hi = 0;
  logic [TW-1:0] cfg_lane = '0;
  logic [TW-1:0] cfg_rd_aset = '0, cfg_rd_ahld = '0, cfg_rd_dset = '0, cfg_rd_dhld = '0, cfg_rd_turn = '0;
  logic [TW-1:0] cfg_wr_aset = '0, cfg_wr_ahld = '0, cfg_wr_dset = '0, cfg_wr_dhld = '0, cfg_wr_turn = '0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic ack;
  logic [DW-1:0] rd_data;
  logic xb_cs_n, xb_oe_n, xb_we_n, xb_adv_n;
  logic [1:0] xb_bl_n;
  logic [AW-1:0] xb_addr;
  logic [DW-1:0] xb_dq_out;
  logic xb_dq_oe;
  logic [DW-1:0] xb_dq_in = 16'hDEAD;
  logic xb_wait = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xbus_async_seq #(.AW(AW), .DW(DW), .TW(TW)) dut (
    .clk(clk), .rst(rst), .cfg_kind(cfg_kind), .cfg_mux(cfg_mux), .cfg_bus8(cfg_bus8),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_hi(cfg_wait_hi), .cfg_lane(cfg_lane),
    .cfg_rd_aset(cfg_rd_aset), .cfg_rd_ahld(cfg_rd_ahld), .cfg_rd_dset(cfg_rd_dset),
    .cfg_rd_dhld(cfg_rd_dhld), .cfg_rd_turn(cfg_rd_turn),
    .cfg_wr_aset(cfg_wr_aset), .cfg_wr_ahld(cfg_wr_ahld), .cfg_wr_dset(cfg_wr_dset),
    .cfg_wr_dhld(cfg_wr_dhld), .cfg_wr_turn(cfg_wr_turn),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rd_data(rd_data),
    .xb_cs_n(xb_cs_n), .xb_oe_n(xb_oe_n), .xb_we_n(xb_we_n), .xb_adv_n(xb_adv_n),
    .xb_bl_n(xb_bl_n), .xb_addr(xb_addr), .xb_dq_out(xb_dq_out), .xb_dq_oe(xb_dq_oe),
    .xb_dq_in(xb_dq_in), .xb_wait(xb_wait)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one access: request already driven; returns at the negedge where ack is seen
  task automatic run_one(input int e_lane, input int e_adv, input int e_addr,
                         input int e_str, input int e_hold, input int e_gap,
                         input logic w, input logic [15:0] wd, input logic [15:0] ad,
                         input logic [1:0] e_bl, input logic [15:0] mask,
                         input logic mux_on, input int wcyc, input logic whi);
    int n_lane = 0, n_adv = 0, n_addr = 0, n_str = 0, n_hold = 0, n_gap = 0;
    int bad_bl = 0, bad_dq = 0, bad_ex = 0, k = 0, wl = wcyc;
    bit seen_act = 0, seen_str = 0, got_ack = 0, ack_idle = 0;
    while (!got_ack && k < 300) begin
      @(negedge clk);
      k++;
      if (ack) begin
        got_ack = 1;
        ack_idle = xb_cs_n && (xb_bl_n == 2'b11) && seen_str;
      end else begin
        if (!(!xb_cs_n || xb_bl_n != 2'b11)) begin
          if (!seen_act) n_gap++;
        end else begin
          seen_act = 1;
        end
        if (xb_bl_n != 2'b11 && xb_bl_n != e_bl) bad_bl++;
        if (xb_cs_n && xb_bl_n != 2'b11) n_lane++;
        if (!xb_cs_n) begin
          if (xb_bl_n != e_bl) bad_bl++;
          if (!xb_oe_n && !xb_we_n) bad_ex++;
          if (!xb_oe_n || !xb_we_n) begin
            seen_str = 1;
            n_str++;
            if (w ? xb_oe_n == 1'b0 : xb_we_n == 1'b0) bad_ex++;
          end else if (!seen_str) begin
            n_addr++;
            if (!xb_adv_n) n_adv++;
            if (mux_on && (!xb_dq_oe || xb_dq_out != (ad & mask))) bad_dq++;
            if (!mux_on && xb_dq_oe) bad_dq++;
          end else begin
            n_hold++;
          end
          if (seen_str && w && (!xb_dq_oe || xb_dq_out != (wd & mask))) bad_dq++;
          if (seen_str && !w && xb_dq_oe) bad_dq++;
        end else if (!xb_oe_n || !xb_we_n) begin
          bad_ex++;
        end
      end
      if (!got_ack && (!xb_oe_n || !xb_we_n)) begin
        if (wl > 0) begin xb_wait = whi; wl--; end
        else xb_wait = !whi;
        xb_dq_in = RBASE + 16'(n_str);
      end else begin
        xb_wait = !whi;
        xb_dq_in = 16'hDEAD;
      end
    end
    chk(got_ack, "R9 ack seen", int'(got_ack), 1);
    chk(n_lane == e_lane, "R4 R6 lane lead cycles", n_lane, e_lane);
    chk(n_adv == e_adv, "R3 address-valid cycles", n_adv, e_adv);
    chk(n_addr == e_addr, w ? "R2 R3 R6 write address cycles" : "R1 R3 R6 read address cycles", n_addr, e_addr);
    chk(n_str == e_str, w ? "R2 R7 R8 write strobe cycles" : "R1 R7 R8 read strobe cycles", n_str, e_str);
    chk(n_hold == e_hold, "R1 R2 R6 data hold cycles", n_hold, e_hold);
    chk(n_gap == e_gap, "R5 turnaround idle cycles", n_gap, e_gap);
    chk(bad_bl == 0, "R4 R10 byte-lane pattern", bad_bl, 0);
    chk(bad_dq == 0, "R2 R3 R10 data pin drive", bad_dq, 0);
    chk(bad_ex == 0, "R11 strobe exclusivity", bad_ex, 0);
    chk(ack_idle, "R9 ack after last bus cycle", int'(ack_idle), 1);
    if (!w) chk(rd_data == ((RBASE + 16'(e_str)) & mask), "R9 R10 read data capture",
                int'(rd_data), int'((RBASE + 16'(e_str)) & mask));
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int prev_turn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(xb_cs_n && xb_oe_n && xb_we_n, "R11 reset strobes high", int'({xb_cs_n, xb_oe_n, xb_we_n}), 7);
    chk(xb_bl_n == 2'b11 && !xb_dq_oe, "R11 reset lanes idle", int'(xb_bl_n), 3);
    chk(!ack, "R11 R9 reset ack low", int'(ack), 0);
    prev_turn = 0;
    for (int i = 0; i < 972; i++) begin
      int lane, a, h, d, dh, t, wcyc, e_str;
      logic w, mux, b8, wen, whi, mux_on;
      logic [1:0] kind, be, e_bl;
      logic [15:0] mask, wd, ad;
      lane = i % 3; a = (i / 3) % 3; h = (i / 9) % 3; d = (i / 27) % 3;
      w = 1'((i / 81) % 2); kind = 2'((i / 162) % 3); mux = 1'((i / 486) % 2);
      dh = (i * 7) % 3; t = (i * 5) % 4; b8 = 1'((i / 5) % 2);
      wen = 1'(((i * 11) >> 2) % 2); whi = 1'(((i * 13) >> 3) % 2);
      wcyc = (i * 3 + i / 7) % 3;
      be = 2'(1 + i % 3);
      mux_on = mux && (kind == 2'd1 || kind == 2'd2);
      mask = b8 ? 16'h00FF : 16'hFFFF;
      e_bl = b8 ? 2'b10 : ~be;
      wd = 16'(16'hC3A1 ^ (i * 16'h0137));
      ad = 16'(16'h1F00 + i * 3);
      e_str = ((d == 0) ? 1 : d) + (wen ? wcyc : 0);
      cfg_kind = kind; cfg_mux = mux; cfg_bus8 = b8; cfg_wait_en = wen; cfg_wait_hi = whi;
      xb_wait = !whi;
      cfg_lane = TW'(lane);
      if (w) begin
        cfg_wr_aset = TW'(a); cfg_wr_ahld = TW'(h); cfg_wr_dset = TW'(d);
        cfg_wr_dhld = TW'(dh); cfg_wr_turn = TW'(t);
        cfg_rd_aset = TW'((a + 1) % 3); cfg_rd_ahld = TW'((h + 1) % 3); cfg_rd_dset = TW'((d + 1) % 3);
        cfg_rd_dhld = TW'((dh + 1) % 3); cfg_rd_turn = TW'((t + 1) % 4);
      end else begin
        cfg_rd_aset = TW'(a); cfg_rd_ahld = TW'(h); cfg_rd_dset = TW'(d);
        cfg_rd_dhld = TW'(dh); cfg_rd_turn = TW'(t);
        cfg_wr_aset = TW'((a + 2) % 3); cfg_wr_ahld = TW'((h + 2) % 3); cfg_wr_dset = TW'((d + 2) % 3);
        cfg_wr_dhld = TW'((dh + 2) % 3); cfg_wr_turn = TW'((t + 2) % 4);
      end
      req_valid = 1'b1; req_write = w; req_addr = ad; req_wdata = wd; req_be = be;
      run_one(lane, mux_on ? a : 0, a + (mux_on ? h : 0), e_str, dh, prev_turn,
              w, wd, ad, e_bl, mask, mux_on, wcyc, whi);
      prev_turn = t;
    end
    repeat (6) @(negedge clk);
    chk(!ack && xb_cs_n, "R9 R11 bus quiet at end", int'(ack), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule